// File: doc/BRIEF.md
# Graphics Frame Buffer Line Fetcher

This block streams a 16-bit-per-pixel graphics plane out of memory into a small local FIFO and hands pixels one at a time to the display timing logic. On an accepted frame trigger it latches a frame start address and walks the frame line by line. Each line starts one programmable byte pitch after the previous one. Each line is read as whole 8-byte FIFO entries, four pixels per entry, through a burst read port. Read data comes back one 8-byte beat per cycle in request order.

Reads are paced by a watermark on free FIFO space. Space already promised to in-flight bursts is counted as used, so the FIFO cannot overflow. A burst is at most 128 bytes and is cut short so that it never crosses a 4 KB address boundary. Two frame start addresses can be alternated on successive frames for double buffering. Pixels use the 1-5-5-5 format and leave the block expanded to 24-bit RGB. The three low bits of each channel are filled with zeros or with a copy of the channel's top bits. Red and blue can be swapped on output.

Frame start addresses and the pitch must be multiples of 8 bytes. The width, height and pitch are held stable while a frame is being fetched. The FIFO depth is a power of two.

Top module: `gfx_line_fetch`

## Requirements
- R1: A read request is presented only when the free entry count (FIFO depth minus stored entries minus requested-but-unreturned entries) is at least `wmark` and at least the burst length.
- R2: A request asks for at most 16 beats of 8 bytes. It never spans a 4 KB boundary: `req_addr[11:0] + 8*req_beats <= 4096`. A burst that would cross is shortened to end at the boundary. A burst is also cut at the end of the line.
- R3: Line n of a frame begins at frame start + n*`pitch`, and each line fetches exactly ceil(`width`/4) entries. Requests of a frame come out in ascending order of line and address, with no gaps, and nothing follows the last line.
- R4: Stored plus outstanding entries never exceed the FIFO depth.
- R5: While `xfer_en` is low, `req_valid` stays low and triggers are ignored. A trigger ignored this way does not start a frame later.
- R6: A one-cycle high on `frame_trig` or `manual_trig` starts a frame when `xfer_en` is high, no frame is in progress, and width and height are nonzero. A trigger while a frame is in progress is ignored.
- R7: With `toggle_en` high, accepted frames alternate between `base0` and `base1`. The first frame after a period with `toggle_en` low uses `base0`. With `toggle_en` low every frame uses `base0`.
- R8: Pixel k (0..3) of an entry sits in data bits [16k+15:16k], and bit 15 of a pixel is ignored. Red is bits [14:10], green [9:5] and blue [4:0]. These appear at `pix_rgb[23:16]`, `[15:8]` and `[7:0]`, top-aligned. `pix_rgb` takes the new pixel at the clock edge that samples `pix_req`. Pixels past `width` in a line's last entry are discarded.
- R9: With `fill_rep` low the three low bits of each output channel are zero. With it high they copy the channel's three most significant bits.
- R10: With `swap_rb` high the red and blue output bytes are exchanged.
- R11: `pix_req` with an empty FIFO leaves `pix_rgb` unchanged and sets `underflow`, which stays set until reset.
- R12: After reset `req_valid`, `pix_rgb` and `underflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en | input | 1 | Enables fetching and trigger acceptance |
| toggle_en | input | 1 | Alternate the two start addresses per frame |
| frame_trig | input | 1 | Frame start pulse from vertical sync |
| manual_trig | input | 1 | Software frame start pulse |
| fill_rep | input | 1 | Low-bit fill: 0 zeros, 1 replicate |
| swap_rb | input | 1 | Exchange red and blue on output |
| base0 | input | ADDR_W | First frame start address |
| base1 | input | ADDR_W | Second frame start address |
| pitch | input | 16 | Line-to-line byte stride |
| width | input | W_W | Pixels per line |
| height | input | H_W | Lines per frame |
| wmark | input | 8 | Free-entry threshold for a burst (0x80 typical) |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Burst byte address, 8-byte aligned |
| req_beats | output | clog2(BURST_BEATS)+1 | Burst length in 8-byte beats |
| rsp_valid | input | 1 | Read data beat valid |
| rsp_data | input | 64 | Read data beat |
| pix_req | input | 1 | Pixel demand from display timing |
| pix_rgb | output | 24 | Expanded pixel |
| underflow | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench aims at lines whose start lies just below a 4 KB boundary. A fetcher that ignored the boundary would issue one burst spanning it, and one that miscomputed the remainder would skip or repeat bytes. Both show up as a wrong request list or wrong pixels. A 13-pixel line leaves one live pixel in its last entry, so a fetcher that failed to drop the padding would shift every following line. A 70-pixel line splits into both line-limited and boundary-limited bursts. Toggle sequences with a stray trigger inside a frame catch a wrong buffer choice or a restart mid-frame. A demand on an empty FIFO at the end catches an output that changes or a flag that clears itself.

// File: rtl/gfx_lf_pkg.sv
// Package: shared constants and pixel expansion for the graphics line fetcher.
// Assumes 8-byte FIFO entries holding four 16-bit pixels, lowest pixel in low bits.
package gfx_lf_pkg;

    localparam int ENTRY_BYTES   = 8;
    localparam int ENTRY_BITS    = ENTRY_BYTES * 8;
    localparam int PIX_BITS      = 16;
    localparam int PIX_PER_ENTRY = ENTRY_BITS / PIX_BITS;

    // Widen one 5-bit channel to 8 bits with zero or replicated low fill.
    function automatic logic [7:0] chan_widen(input logic [4:0] c, input logic rep);
        return {c, (rep ? c[4:2] : 3'b000)};
    endfunction

    // Expand a 1-5-5-5 pixel to 24-bit RGB, optionally swapping red and blue.
    function automatic logic [23:0] px_expand(input logic [15:0] px,
                                              input logic rep,
                                              input logic swp);
        logic [7:0] r8, g8, b8;
        r8 = chan_widen(px[14:10], rep);
        g8 = chan_widen(px[9:5], rep);
        b8 = chan_widen(px[4:0], rep);
        return swp ? {b8, g8, r8} : {r8, g8, b8};
    endfunction

endpackage

// File: rtl/gfx_lf_fifo.sv
// Module: synchronous FIFO of 8-byte entries with an occupancy count.
// Assumes DEPTH is a power of two and that the writer never writes when full
// (guaranteed upstream by credit accounting).
module gfx_lf_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wp_q] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= wp_q + AW'(1);
            if (rd_en) rp_q <= rp_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(wr_en) - (AW+1)'(rd_en);
        end
    end

    assign rd_data = mem_q[rp_q];
    assign count   = cnt_q;
    assign empty   = (cnt_q == '0);
endmodule

// File: rtl/gfx_lf_addr_gen.sv
// Module: frame/line walker, burst sizing and FIFO credit accounting.
// Assumes 8-byte aligned start addresses and pitch, and width/height/pitch held
// stable during a frame. Responses return one beat per cycle in request order.
module gfx_lf_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int W_W         = 12,
    parameter int H_W         = 12,
    parameter int DEPTH       = 128,
    parameter int BURST_BEATS = 16,
    parameter int BOUND_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xfer_en,
    input  logic                          toggle_en,
    input  logic                          trig,
    input  logic [ADDR_W-1:0]             base0,
    input  logic [ADDR_W-1:0]             base1,
    input  logic [15:0]                   pitch,
    input  logic [W_W-1:0]                width,
    input  logic [H_W-1:0]                height,
    input  logic [7:0]                    wmark,
    input  logic [$clog2(DEPTH):0]        fifo_cnt,
    input  logic                          rsp_valid,
    input  logic                          req_ready,
    output logic                          req_valid,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [$clog2(BURST_BEATS):0]  req_beats,
    output logic [$clog2(DEPTH):0]        outst
);
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int BLW   = $clog2(BURST_BEATS) + 1;
    localparam int BND_W = $clog2(BOUND_BYTES);
    localparam int ESH   = $clog2(gfx_lf_pkg::ENTRY_BYTES);

    logic                busy_q, sel_q;
    logic [H_W-1:0]      line_q;
    logic [ADDR_W-1:0]   line_base_q, cur_q;
    logic [W_W-1:0]      left_q;
    logic [CW-1:0]       outst_q;

    logic [W_W-1:0]      ents_line;
    logic [15:0]         to_bound, burst, free_ent;
    logic                fire, hs, line_done;
    logic [ADDR_W-1:0]   start_addr, next_line;

    // Entries per line: four pixels per 8-byte entry, rounded up.
    assign ents_line = W_W'(({1'b0, width} + (W_W+1)'(3)) >> 2);

    // Burst length: smallest of line remainder, burst cap and boundary room.
    always_comb begin
        to_bound = (16'(BOUND_BYTES) - 16'(cur_q[BND_W-1:0])) >> ESH;
        burst    = 16'(left_q);
        if (burst > 16'(BURST_BEATS)) burst = 16'(BURST_BEATS);
        if (burst > to_bound)         burst = to_bound;
    end

    // Free entries not already claimed by stored or in-flight data.
    assign free_ent  = 16'(DEPTH) - 16'(fifo_cnt) - 16'(outst_q);

    assign req_valid = busy_q & xfer_en & (free_ent >= 16'(wmark)) & (free_ent >= burst);
    assign req_addr  = {cur_q[ADDR_W-1:ESH], {ESH{1'b0}}};
    assign req_beats = BLW'(burst);
    assign outst     = outst_q;

    assign hs         = req_valid & req_ready;
    assign line_done  = (16'(left_q) == burst);
    assign fire       = trig & xfer_en & ~busy_q & (|width) & (|height);
    assign start_addr = (toggle_en & sel_q) ? base1 : base0;
    assign next_line  = line_base_q + ADDR_W'(pitch);

    // Outstanding beat credit: add on accepted burst, release per returned beat.
    always_ff @(posedge clk) begin
        if (!rst_n) outst_q <= '0;
        else        outst_q <= outst_q + (hs ? CW'(burst) : CW'(0)) - CW'(rsp_valid);
    end

    // Frame start, buffer selection and line/burst walking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            sel_q       <= 1'b0;
            line_q      <= '0;
            line_base_q <= '0;
            cur_q       <= '0;
            left_q      <= '0;
        end else if (fire) begin
            busy_q      <= 1'b1;
            sel_q       <= toggle_en ? ~sel_q : 1'b0;
            line_q      <= '0;
            line_base_q <= start_addr;
            cur_q       <= start_addr;
            left_q      <= ents_line;
        end else begin
            if (!toggle_en) sel_q <= 1'b0;
            if (hs) begin
                if (line_done) begin
                    if (line_q == height - H_W'(1)) begin
                        busy_q <= 1'b0;
                    end else begin
                        line_q      <= line_q + H_W'(1);
                        line_base_q <= next_line;
                        cur_q       <= next_line;
                        left_q      <= ents_line;
                    end
                end else begin
                    left_q <= left_q - W_W'(burst);
                    cur_q  <= cur_q + (ADDR_W'(burst) << ESH);
                end
            end
        end
    end
endmodule

// File: rtl/gfx_lf_unpack.sv
// Module: pixel extraction from the FIFO head entry and RGB expansion.
// Assumes every line starts on a fresh entry; pops after the fourth pixel of an
// entry or after the last pixel of a line, discarding padding pixels.
module gfx_lf_unpack #(
    parameter int W_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pix_req,
    input  logic                            fifo_empty,
    input  logic [gfx_lf_pkg::ENTRY_BITS-1:0] fifo_data,
    input  logic [W_W-1:0]                  width,
    input  logic                            fill_rep,
    input  logic                            swap_rb,
    output logic                            pop,
    output logic [23:0]                     pix_rgb,
    output logic                            underflow
);
    import gfx_lf_pkg::*;

    logic [W_W-1:0]      px_q;
    logic [PIX_BITS-1:0] lane [PIX_PER_ENTRY];
    logic                take, last_px;

    // Slice the head entry into pixel lanes.
    for (genvar i = 0; i < PIX_PER_ENTRY; i++) begin : g_lane
        assign lane[i] = fifo_data[i*PIX_BITS +: PIX_BITS];
    end

    assign take    = pix_req & ~fifo_empty;
    assign last_px = (px_q == width - W_W'(1));
    assign pop     = take & ((px_q[1:0] == 2'd3) | last_px);

    // Pixel register, in-line position and sticky underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q      <= '0;
            pix_rgb   <= '0;
            underflow <= 1'b0;
        end else begin
            if (take) begin
                pix_rgb <= px_expand(lane[px_q[1:0]], fill_rep, swap_rb);
                px_q    <= last_px ? '0 : px_q + W_W'(1);
            end
            if (pix_req && fifo_empty) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/gfx_line_fetch.sv
// Module: top of the graphics line fetcher; joins the address walker, the
// entry FIFO and the pixel unpacker. Memory beats are written straight into the
// FIFO; space for them was reserved when the burst was requested.
module gfx_line_fetch #(
    parameter int ADDR_W      = 32,
    parameter int W_W         = 12,
    parameter int H_W         = 12,
    parameter int DEPTH       = 128,
    parameter int BURST_BEATS = 16,
    parameter int BOUND_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xfer_en,
    input  logic                          toggle_en,
    input  logic                          frame_trig,
    input  logic                          manual_trig,
    input  logic                          fill_rep,
    input  logic                          swap_rb,
    input  logic [ADDR_W-1:0]             base0,
    input  logic [ADDR_W-1:0]             base1,
    input  logic [15:0]                   pitch,
    input  logic [W_W-1:0]                width,
    input  logic [H_W-1:0]                height,
    input  logic [7:0]                    wmark,
    output logic                          req_valid,
    input  logic                          req_ready,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [$clog2(BURST_BEATS):0]  req_beats,
    input  logic                          rsp_valid,
    input  logic [63:0]                   rsp_data,
    input  logic                          pix_req,
    output logic [23:0]                   pix_rgb,
    output logic                          underflow
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] fifo_cnt;
    logic [CW-1:0] outst;
    logic          fifo_empty;
    logic          fifo_pop;
    logic [63:0]   head_data;

    gfx_lf_addr_gen #(
        .ADDR_W(ADDR_W), .W_W(W_W), .H_W(H_W), .DEPTH(DEPTH),
        .BURST_BEATS(BURST_BEATS), .BOUND_BYTES(BOUND_BYTES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .toggle_en(toggle_en),
        .trig(frame_trig | manual_trig), .base0(base0), .base1(base1),
        .pitch(pitch), .width(width), .height(height), .wmark(wmark),
        .fifo_cnt(fifo_cnt), .rsp_valid(rsp_valid), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats),
        .outst(outst)
    );

    gfx_lf_fifo #(.DEPTH(DEPTH), .DW(64)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(rsp_valid), .wr_data(rsp_data),
        .rd_en(fifo_pop), .rd_data(head_data), .count(fifo_cnt),
        .empty(fifo_empty)
    );

    gfx_lf_unpack #(.W_W(W_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .fifo_empty(fifo_empty),
        .fifo_data(head_data), .width(width), .fill_rep(fill_rep),
        .swap_rb(swap_rb), .pop(fifo_pop), .pix_rgb(pix_rgb),
        .underflow(underflow)
    );
endmodule

// File: rtl/gfx_lf_checker.sv
// Module: property checker for the line fetcher, bound into the top module.
module gfx_lf_checker #(
    parameter int ADDR_W      = 32,
    parameter int DEPTH       = 128,
    parameter int BURST_BEATS = 16,
    parameter int BOUND_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xfer_en,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [$clog2(BURST_BEATS):0]  req_beats,
    input  logic [$clog2(DEPTH):0]        fifo_cnt,
    input  logic [$clog2(DEPTH):0]        outst,
    input  logic                          fifo_empty,
    input  logic                          pix_req,
    input  logic [23:0]                   pix_rgb,
    input  logic                          underflow
);
    localparam int BND_W = $clog2(BOUND_BYTES);

    // R4: stored plus in-flight entries fit in the FIFO.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (16'(fifo_cnt) + 16'(outst)) <= 16'(DEPTH));

    // R2: burst length within 1..cap and no 4 KB crossing.
    a_r2_burst_shape: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_beats != '0) && (32'(req_beats) <= 32'(BURST_BEATS)) &&
                      ((32'(req_addr[BND_W-1:0]) + (32'(req_beats) << 3)) <= 32'(BOUND_BYTES)));

    // R5: no request while transfers are disabled.
    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> xfer_en);

    // R11: underflow flag is sticky.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R11: demand on an empty FIFO holds the pixel and raises the flag.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && fifo_empty) |=> ($stable(pix_rgb) && underflow));
endmodule

bind gfx_line_fetch gfx_lf_checker #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BURST_BEATS(BURST_BEATS), .BOUND_BYTES(BOUND_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_beats(req_beats), .fifo_cnt(fifo_cnt),
    .outst(outst), .fifo_empty(fifo_empty), .pix_req(pix_req),
    .pix_rgb(pix_rgb), .underflow(underflow)
);

// File: tb/gfx_line_fetch_bench.sv
module gfx_line_fetch_bench;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_en = 1'b1, toggle_en = 1'b0, frame_trig = 1'b0, manual_trig = 1'b0;
    logic        fill_rep = 1'b0, swap_rb = 1'b0;
    logic [31:0] base0 = 32'h0, base1 = 32'h0;
    logic [15:0] pitch = 16'd64;
    logic [11:0] width = 12'd13, height = 12'd4;
    logic [7:0]  wmark = 8'd8;
    logic        req_valid, req_ready, rsp_valid, pix_req, underflow;
    logic [31:0] req_addr;
    logic [4:0]  req_beats;
    logic [63:0] rsp_data;
    logic [23:0] pix_rgb;

    always #2 clk = ~clk;

    gfx_line_fetch #(.DEPTH(DEPTH)) u_gfx_line_fetch (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .toggle_en(toggle_en),
        .frame_trig(frame_trig), .manual_trig(manual_trig), .fill_rep(fill_rep),
        .swap_rb(swap_rb), .base0(base0), .base1(base1), .pitch(pitch),
        .width(width), .height(height), .wmark(wmark), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pix_req(pix_req),
        .pix_rgb(pix_rgb), .underflow(underflow)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    int cyc = 0;
    int exp_a[$];
    int exp_b[$];
    logic [31:0] rspq[$];
    int req_total = 0, popped = 0, valid_seen = 0;
    int cur_w = 13, bpx = 0, wm = 8;
    bit count_pops = 1;
    string rtag = "R3";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] wfun(input logic [31:0] a);
        return a[16:1] ^ {a[8:1], a[16:9]};
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [15:0] p, input bit rep, input bit swp);
        logic [7:0] r, g, b;
        r = {p[14:10], rep ? p[14:12] : 3'b0};
        g = {p[9:5],   rep ? p[9:7]   : 3'b0};
        b = {p[4:0],   rep ? p[4:2]   : 3'b0};
        return swp ? {b, g, r} : {r, g, b};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Bench-side FIFO pop tracking (entries leave after 4th pixel or line end).
    always @(posedge clk) begin
        if (pix_req && count_pops) begin
            if ((bpx % 4) == 3 || bpx == cur_w - 1) popped <= popped + 1;
            bpx <= (bpx == cur_w - 1) ? 0 : bpx + 1;
        end
    end

    // Memory model: accepts requests, returns beats in order, checks requests.
    initial begin
        logic [31:0] a;
        int free, ea, eb;
        req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
        forever begin
            @(negedge clk);
            if (rspq.size() > 0 && (cyc % 4) != 2) begin
                a = rspq.pop_front();
                rsp_valid = 1'b1;
                rsp_data  = {wfun(a + 6), wfun(a + 4), wfun(a + 2), wfun(a)};
            end else begin
                rsp_valid = 1'b0;
            end
            if (req_valid) valid_seen++;
            req_ready = (cyc % 3) != 1;
            if (req_valid && req_ready) begin
                free = DEPTH - (req_total - popped);
                checks++;
                if (free < wm || free < int'(req_beats)) begin
                    fails++;
                    $display("FAIL R1/R4 free actual=%0d expected>=%0d and >=%0d", free, wm, req_beats);
                end
                if (exp_a.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R3 unexpected request actual=%0h expected=none", req_addr);
                end else begin
                    ea = exp_a.pop_front();
                    eb = exp_b.pop_front();
                    chk(rtag, {req_addr, 27'b0, req_beats}, {ea[31:0], eb[31:0]});
                end
                for (int i = 0; i < int'(req_beats); i++) rspq.push_back(req_addr + 32'(8 * i));
                req_total += int'(req_beats);
            end
        end
    end

    // Expected burst list (R2, R3): line start + pitch, cut at 16 beats, 4 KB and line end.
    task automatic push_frame(input int base, input int w, input int h, input int pt);
        for (int l = 0; l < h; l++) begin
            int a, left;
            a = base + l * pt;
            left = (w + 3) / 4;
            while (left > 0) begin
                int tb, bl;
                tb = (4096 - (a % 4096)) / 8;
                bl = left;
                if (bl > 16) bl = 16;
                if (bl > tb) bl = tb;
                exp_a.push_back(a);
                exp_b.push_back(bl);
                a += bl * 8;
                left -= bl;
            end
        end
    endtask

    task automatic run_frame(input int base, input int w, input int h, input int pt,
                             input bit rep, input bit swp, input bit man, input bit dbl,
                             input string ptag, input string rt);
        cur_w = w; width = 12'(w); height = 12'(h); pitch = 16'(pt);
        fill_rep = rep; swap_rb = swp; rtag = rt;
        push_frame(base, w, h, pt);
        @(negedge clk);
        if (man) manual_trig = 1'b1; else frame_trig = 1'b1;
        @(negedge clk);
        manual_trig = 1'b0; frame_trig = 1'b0;
        if (dbl) begin
            // R6: trigger during a running frame must not restart it
            @(negedge clk); frame_trig = 1'b1;
            @(negedge clk); frame_trig = 1'b0;
        end
        repeat (150) @(negedge clk);
        for (int l = 0; l < h; l++) begin
            for (int x = 0; x < w; x++) begin
                pix_req = 1'b1;
                @(negedge clk);
                pix_req = 1'b0;
                chk(ptag, 64'(pix_rgb), 64'(exp_rgb(wfun(32'(base + l * pt + 2 * x)), rep, swp)));
                if ((x % 5) == 0) @(negedge clk);
            end
        end
        repeat (20) @(negedge clk);
        chk("R3 leftover bursts", 64'(exp_a.size()), 64'd0);
    endtask

    initial begin
        logic [23:0] prev;
        int vs;
        pix_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 req_valid", 64'(req_valid), 64'd0);
        chk("R12 pix_rgb", 64'(pix_rgb), 64'd0);
        chk("R12 underflow", 64'(underflow), 64'd0);

        base0 = 32'h0000_0FF0; base1 = 32'h0000_2000;
        // manual trigger, base0, boundary split, zero fill
        run_frame(32'h0FF0, 13, 4, 64, 1'b0, 1'b0, 1'b1, 1'b0, "R8", "R6");
        toggle_en = 1'b1;
        run_frame(32'h0FF0, 13, 4, 64, 1'b1, 1'b0, 1'b0, 1'b0, "R9", "R7");
        run_frame(32'h2000, 13, 4, 64, 1'b0, 1'b1, 1'b0, 1'b1, "R10", "R6");
        run_frame(32'h0FF0, 13, 4, 64, 1'b0, 1'b0, 1'b0, 1'b0, "R8", "R7");
        toggle_en = 1'b0; wm = 16; wmark = 8'd16;
        base0 = 32'h0000_1F90;
        run_frame(32'h1F90, 70, 3, 160, 1'b1, 1'b1, 1'b0, 1'b0, "R9", "R2");

        // R5: trigger with transfers disabled produces nothing, now or later
        xfer_en = 1'b0;
        vs = valid_seen;
        @(negedge clk); frame_trig = 1'b1;
        @(negedge clk); frame_trig = 1'b0;
        repeat (60) @(negedge clk);
        chk("R5 disabled", 64'(valid_seen - vs), 64'd0);
        xfer_en = 1'b1;
        repeat (60) @(negedge clk);
        chk("R5 after enable", 64'(valid_seen - vs), 64'd0);

        // R11: demand on empty FIFO
        count_pops = 0;
        chk("R11 flag clear", 64'(underflow), 64'd0);
        prev = pix_rgb;
        pix_req = 1'b1;
        @(negedge clk);
        pix_req = 1'b0;
        chk("R11 flag set", 64'(underflow), 64'd1);
        chk("R11 pixel held", 64'(pix_rgb), 64'(prev));
        repeat (5) @(negedge clk);
        chk("R11 flag sticky", 64'(underflow), 64'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule